// File: doc/BRIEF.md
# Load/Store Address Fault Checker

This block sits between operation decode and the memory bus of a processor. For each decoded load or store it forms the virtual address from a base register and a sign-extended 16-bit offset, presents the page number to an external translation lookup, and then applies a fixed, prioritized set of fault checks: alignment, privilege, translation miss, translation invalid and, for stores only, write protection. Only an access that passes every check turns into a one-cycle bus request. That request carries the translated frame joined with the page offset, plus the transfer size and direction.

A faulting access raises a one-cycle fault pulse with a code and never reaches the bus. For the five address faults, the faulting virtual address is latched into a bad-address register for the trap handler. Once a request is issued, the block waits for a bus acknowledge. If none arrives within a parameterized number of cycles, it raises a bus-timeout fault and leaves the bad-address register untouched. While it waits, new operations are not accepted.

Top module: `ldst_addr_guard`

## Requirements
- R1: The virtual address is `baseReg + sign_extend(immVal)` taken modulo 2^32. `pageNum` carries its bits 31..12 combinationally in the same cycle as the operation.
- R2: An operation is accepted only when `opValid`, `ready` and `opCode[5:3]==3'b110` all hold. The low three opcode bits select the access: 0 word load, 1 signed half load, 2 unsigned half load, 3 signed byte load, 4 unsigned byte load, 5 word store, 6 half store, 7 byte store. Any other opcode produces neither a request nor a fault.
- R3: A half access with address bit 0 set, or a word access with either of bits 1..0 set, faults with code 1 (alignment). Byte accesses never fault on alignment.
- R4: An access with address bit 31 set while `userMode` is 1 faults with code 2 (privilege).
- R5: `tlbHit==0` faults with code 3 (miss). A hit with `tlbValid==0` faults with code 4 (invalid).
- R6: A store whose entry has `tlbWrite==0` faults with code 5 (write protect). Loads ignore `tlbWrite`.
- R7: Only the first failing check is reported, in this order: alignment, privilege, miss, invalid, write protect.
- R8: Faults 1 to 5 load the virtual address into `badAddr`, visible in the same cycle as the fault pulse. No other event changes `badAddr`, which resets to 0.
- R9: A fault-free accepted access raises `busReq` for exactly one cycle, the cycle after acceptance. In that cycle `busAddr = {tlbFrame, va[11:0]}`, `busWrite` is 1 for stores, and `busSize` is 0 for byte, 1 for half and 2 for word.
- R10: The bus-response window is the `TIMEOUT` cycles (default 16) starting with the `busReq` cycle. An acknowledge anywhere in the window ends the wait with no fault. If no acknowledge arrives, the cycle after the window shows a fault with code 6, and `badAddr` stays unchanged.
- R11: A fault shows as `faultValid` high for one cycle with `faultCode` nonzero, and no `busReq` for that access. `faultCode` is 0 whenever `faultValid` is low.
- R12: `ready` is low from the `busReq` cycle until the wait ends. `opValid` during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Decoded operation present |
| opCode | input | 6 | Operation code |
| baseReg | input | 32 | Base register value |
| immVal | input | 16 | Signed offset |
| userMode | input | 1 | 1 = user mode, 0 = kernel mode |
| pageNum | output | 20 | Page number to translation lookup |
| tlbHit | input | 1 | Lookup found an entry |
| tlbValid | input | 1 | Entry valid bit |
| tlbWrite | input | 1 | Entry write-permit bit |
| tlbFrame | input | 20 | Entry frame number |
| ready | output | 1 | Block can accept an operation |
| busReq | output | 1 | One-cycle bus request strobe |
| busAddr | output | 32 | Physical address of request |
| busWrite | output | 1 | Request is a store |
| busSize | output | 2 | Transfer size: 0 byte, 1 half, 2 word |
| busAck | input | 1 | Bus acknowledge |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCode | output | 3 | Fault code, 0 when no fault |
| badAddr | output | 32 | Faulting virtual address register |

## Verification
The bench stacks several fault conditions on one access, so a checker with its priority chain reordered reports the wrong code. It also runs byte accesses at odd addresses and loads with the write bit clear: a design that over-checks alignment or applies write protection to loads raises spurious faults there. Acknowledges land on the last cycle of the response window and also never arrive. An off-by-one counter therefore either times out an answered request or misses the timeout, and a timeout that touches `badAddr` shows up as a register mismatch. A faulting operation is offered while a request is still pending, and a block that accepts it pulses a fault it should not.

// File: rtl/ldst_guard_pkg.sv
package ldst_guard_pkg;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_ALIGN       = 3'd1,
    FLT_PRIV        = 3'd2,
    FLT_TLB_MISS    = 3'd3,
    FLT_TLB_INVALID = 3'd4,
    FLT_TLB_WRITE   = 3'd5,
    FLT_BUS_TIMEOUT = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture request fields
    logic loadBad;   // capture faulting virtual address
  } strobe_t;

endpackage

// File: rtl/ldst_guard_datapath.sv
module ldst_guard_datapath
  import ldst_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int OFFS_W = 12,
  parameter int OP_W   = 6,
  localparam int PN_W  = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opCode,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              userMode,
  input  logic              tlbHit,
  input  logic              tlbValid,
  input  logic              tlbWrite,
  input  logic [PN_W-1:0]   tlbFrame,
  input  strobe_t           strobes,
  output logic [PN_W-1:0]   pageNum,
  output logic              opLegal,
  output fault_e            checkCode,
  output logic [ADDR_W-1:0] busAddr,
  output size_e             busSize,
  output logic              busWrite,
  output logic [ADDR_W-1:0] badAddr
);

  localparam int SEL_W = 3;

  logic [ADDR_W-1:0] virtAddr;
  logic [SEL_W-1:0]  accSel;
  logic              isStore;
  size_e             accSize;
  logic              misaligned;

  assign virtAddr = baseReg + {{(ADDR_W-IMM_W){immVal[IMM_W-1]}}, immVal};
  assign pageNum  = virtAddr[ADDR_W-1:OFFS_W];

  // decode: upper opcode bits select the load/store group
  assign opLegal = (opCode[OP_W-1:SEL_W] == 3'b110);
  assign accSel  = opCode[SEL_W-1:0];
  assign isStore = (accSel >= 3'd5);

  always_comb begin
    unique case (accSel)
      3'd0, 3'd5:       accSize = SZ_WORD;
      3'd1, 3'd2, 3'd6: accSize = SZ_HALF;
      default:          accSize = SZ_BYTE;
    endcase
  end

  assign misaligned = ((accSize == SZ_HALF) && virtAddr[0]) ||
                      ((accSize == SZ_WORD) && (|virtAddr[1:0]));

  // priority chain, first failing check wins
  always_comb begin
    if (misaligned)                         checkCode = FLT_ALIGN;
    else if (virtAddr[ADDR_W-1] && userMode) checkCode = FLT_PRIV;
    else if (!tlbHit)                       checkCode = FLT_TLB_MISS;
    else if (!tlbValid)                     checkCode = FLT_TLB_INVALID;
    else if (isStore && !tlbWrite)          checkCode = FLT_TLB_WRITE;
    else                                    checkCode = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busAddr  <= '0;
      busSize  <= SZ_BYTE;
      busWrite <= 1'b0;
      badAddr  <= '0;
    end else begin
      if (strobes.loadReq) begin
        busAddr  <= {tlbFrame, virtAddr[OFFS_W-1:0]};
        busSize  <= accSize;
        busWrite <= isStore;
      end
      if (strobes.loadBad) begin
        badAddr <= virtAddr;
      end
    end
  end

  // R11: control never asks for a request and a fault capture together
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.loadReq, strobes.loadBad}));

  // R6: a clean store implies write permission was present
  p_wr_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadReq && isStore) |-> tlbWrite);

  // R8: bad-address register moves only after a capture strobe
  p_bad_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(badAddr) |-> $past(strobes.loadBad));

  // R9: a request is only captured for an access that passed every check
  p_req_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.loadReq |-> (opLegal && tlbHit && tlbValid));

endmodule

// File: rtl/ldst_guard_control.sv
module ldst_guard_control
  import ldst_guard_pkg::*;
#(
  parameter int TIMEOUT = 16,
  localparam int CNT_W  = $clog2(TIMEOUT) + 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    opValid,
  input  logic    opLegal,
  input  fault_e  checkCode,
  input  logic    busAck,
  output strobe_t strobes,
  output logic    ready,
  output logic    busReq,
  output logic    faultValid,
  output fault_e  faultCode
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e            state;
  logic [CNT_W-1:0]  waitCnt;
  logic              accept;
  logic              timeoutHit;

  assign ready      = (state == ST_IDLE);
  assign accept     = ready && opValid && opLegal;
  assign timeoutHit = (state == ST_WAIT) && !busAck &&
                      (waitCnt == CNT_W'(TIMEOUT - 1));

  always_comb begin
    strobes.loadReq = accept && (checkCode == FLT_NONE);
    strobes.loadBad = accept && (checkCode != FLT_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      waitCnt    <= '0;
      busReq     <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= FLT_NONE;
    end else begin
      busReq     <= strobes.loadReq;
      faultValid <= strobes.loadBad || timeoutHit;
      if (strobes.loadBad)  faultCode <= checkCode;
      else if (timeoutHit)  faultCode <= FLT_BUS_TIMEOUT;
      else                  faultCode <= FLT_NONE;

      unique case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (strobes.loadReq) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (busAck || timeoutHit) begin
            state   <= ST_IDLE;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: request is a single-cycle pulse
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busReq |=> !busReq);

  // R11: a fault never coincides with a request
  p_no_req_on_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busReq && faultValid));

  // R11: code reads zero outside the fault pulse
  p_code_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !faultValid |-> (faultCode == FLT_NONE));

  // R10: wait counter stays inside the response window
  p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (waitCnt < CNT_W'(TIMEOUT)));

  // R10: a timeout only follows a waiting cycle
  p_timeout_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (faultValid && faultCode == FLT_BUS_TIMEOUT) |-> ($past(state) == ST_WAIT));

  // R12: not ready while the request is out
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busReq |-> !ready);

endmodule

// File: rtl/ldst_addr_guard.sv
module ldst_addr_guard
  import ldst_guard_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int OFFS_W  = 12,
  parameter int OP_W    = 6,
  parameter int TIMEOUT = 16,
  localparam int PN_W   = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              userMode,
  output logic [PN_W-1:0]   pageNum,
  input  logic              tlbHit,
  input  logic              tlbValid,
  input  logic              tlbWrite,
  input  logic [PN_W-1:0]   tlbFrame,
  output logic              ready,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [1:0]        busSize,
  input  logic              busAck,
  output logic              faultValid,
  output logic [2:0]        faultCode,
  output logic [ADDR_W-1:0] badAddr
);

  strobe_t strobes;
  logic    opLegal;
  fault_e  checkCode;
  fault_e  faultCodeE;
  size_e   busSizeE;

  ldst_guard_datapath #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .OFFS_W(OFFS_W), .OP_W(OP_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .baseReg(baseReg),
    .immVal(immVal), .userMode(userMode), .tlbHit(tlbHit),
    .tlbValid(tlbValid), .tlbWrite(tlbWrite), .tlbFrame(tlbFrame),
    .strobes(strobes), .pageNum(pageNum), .opLegal(opLegal),
    .checkCode(checkCode), .busAddr(busAddr), .busSize(busSizeE),
    .busWrite(busWrite), .badAddr(badAddr)
  );

  ldst_guard_control #(
    .TIMEOUT(TIMEOUT)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opLegal(opLegal),
    .checkCode(checkCode), .busAck(busAck), .strobes(strobes),
    .ready(ready), .busReq(busReq), .faultValid(faultValid),
    .faultCode(faultCodeE)
  );

  assign faultCode = faultCodeE;
  assign busSize   = busSizeE;

endmodule

// File: tb/tb_ldst_addr_guard.sv
`timescale 1ns/1ps
module tb_ldst_addr_guard;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [5:0]  opCode = '0;
  logic [31:0] baseReg = '0;
  logic [15:0] immVal = '0;
  logic        userMode = 1'b0;
  logic [19:0] pageNum;
  logic        tlbHit = 1'b0, tlbValid = 1'b0, tlbWrite = 1'b0;
  logic [19:0] tlbFrame = '0;
  logic        ready, busReq, busWrite, busAck = 1'b0, faultValid;
  logic [31:0] busAddr, badAddr;
  logic [1:0]  busSize;
  logic [2:0]  faultCode;

  int checks = 0;
  int failures = 0;
  logic [31:0] expBad = '0;
  string curTag = "";
  int injectAt = -1;
  bit done = 0;

  ldst_addr_guard #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .baseReg(baseReg), .immVal(immVal), .userMode(userMode),
    .pageNum(pageNum), .tlbHit(tlbHit), .tlbValid(tlbValid),
    .tlbWrite(tlbWrite), .tlbFrame(tlbFrame), .ready(ready),
    .busReq(busReq), .busAddr(busAddr), .busWrite(busWrite),
    .busSize(busSize), .busAck(busAck), .faultValid(faultValid),
    .faultCode(faultCode), .badAddr(badAddr)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", curTag, req, act, exp);
    end
  endtask

  function automatic logic [2:0] expFault(input logic [2:0] sel, input logic [31:0] va,
      input logic usr, input logic hit, input logic vld, input logic wr);
    logic st;
    logic mis;
    st  = (sel >= 3'd5);
    mis = ((sel == 3'd0 || sel == 3'd5) && va[1:0] != 2'b00) ||
          ((sel == 3'd1 || sel == 3'd2 || sel == 3'd6) && va[0]);
    if (mis)               return 3'd1;
    if (va[31] && usr)     return 3'd2;
    if (!hit)              return 3'd3;
    if (!vld)              return 3'd4;
    if (st && !wr)         return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [1:0] expSize(input logic [2:0] sel);
    if (sel == 3'd0 || sel == 3'd5) return 2'd2;
    if (sel == 3'd1 || sel == 3'd2 || sel == 3'd6) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string codeTag(input logic [2:0] c);
    case (c)
      3'd1: return "R3 align";
      3'd2: return "R4 priv";
      3'd3, 3'd4: return "R5 tlb";
      3'd5: return "R6 wprot";
      default: return "R11 code";
    endcase
  endfunction

  task automatic runOp(input logic [5:0] op, input logic [31:0] base, input logic [15:0] imm,
      input logic usr, input logic hit, input logic vld, input logic wr,
      input logic [19:0] frame, input int ackDly);
    logic [31:0] va;
    logic [2:0]  code;
    logic        legal;
    @(negedge clk);
    opCode = op; baseReg = base; immVal = imm; userMode = usr;
    tlbHit = hit; tlbValid = vld; tlbWrite = wr; tlbFrame = frame;
    opValid = 1'b1; busAck = 1'b0;
    va = base + {{16{imm[15]}}, imm};
    #1;
    chk("R1 pageNum", 64'(pageNum), 64'(va[31:12]));
    chk("R12 ready idle", 64'(ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    legal = (op[5:3] == 3'b110);
    code  = legal ? expFault(op[2:0], va, usr, hit, vld, wr) : 3'd0;
    if (!legal) begin
      chk("R2 illegal no req", 64'(busReq), 64'd0);
      chk("R2 illegal no fault", 64'(faultValid), 64'd0);
      chk("R8 bad unchanged", 64'(badAddr), 64'(expBad));
    end else if (code != 3'd0) begin
      chk("R11 fault pulse", 64'(faultValid), 64'd1);
      chk(codeTag(code), 64'(faultCode), 64'(code));
      chk("R11 no req", 64'(busReq), 64'd0);
      expBad = va;
      chk("R8 bad capture", 64'(badAddr), 64'(expBad));
      @(negedge clk);
      chk("R11 pulse ends", 64'(faultValid), 64'd0);
      chk("R11 code zero", 64'(faultCode), 64'd0);
    end else begin
      chk("R9 req", 64'(busReq), 64'd1);
      chk("R9 addr", 64'(busAddr), 64'({frame, va[11:0]}));
      chk("R9 write", 64'(busWrite), 64'(op[2:0] >= 3'd5));
      chk("R9 size", 64'(busSize), 64'(expSize(op[2:0])));
      chk("R11 no fault", 64'(faultValid), 64'd0);
      chk("R8 bad unchanged", 64'(badAddr), 64'(expBad));
      for (int k = 0; ; k++) begin
        chk("R12 busy", 64'(ready), 64'd0);
        busAck = (k == ackDly);
        if (k == injectAt) begin
          opValid = 1'b1; opCode = 6'b110000; baseReg = 32'h3; immVal = '0;
        end else begin
          opValid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        busAck = 1'b0;
        opValid = 1'b0;
        if (k == ackDly) begin
          chk("R10 acked no fault", 64'(faultValid), 64'd0);
          chk("R10 ready after ack", 64'(ready), 64'd1);
          break;
        end
        if (k == TMO - 1) begin
          chk("R10 timeout pulse", 64'(faultValid), 64'd1);
          chk("R10 timeout code", 64'(faultCode), 64'd6);
          chk("R10 bad unchanged", 64'(badAddr), 64'(expBad));
          chk("R10 ready", 64'(ready), 64'd1);
          break;
        end
        chk("R12 no fault while busy", 64'(faultValid), 64'd0);
        chk("R12 no req while busy", 64'(busReq), 64'd0);
      end
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    curTag = "reset";
    chk("R11 faultValid", 64'(faultValid), 64'd0);
    chk("R9 busReq", 64'(busReq), 64'd0);
    chk("R8 badAddr", 64'(badAddr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready", 64'(ready), 64'd1);

    curTag = "sext";
    runOp(6'b110000, 32'h0000_1000, 16'hFFFC, 0, 1, 1, 1, 20'hABCDE, 0);
    runOp(6'b110101, 32'h7FFF_FFF0, 16'h0010, 0, 1, 1, 1, 20'h00011, 2);
    curTag = "align";
    runOp(6'b110011, 32'h0000_2003, 16'h0000, 0, 1, 1, 1, 20'h12345, 0);
    runOp(6'b110111, 32'h0000_2001, 16'h0000, 0, 1, 1, 1, 20'h12345, 1);
    runOp(6'b110001, 32'h0000_2001, 16'h0000, 0, 1, 1, 1, 20'h12345, 0);
    runOp(6'b110010, 32'h0000_2002, 16'h0000, 0, 1, 1, 1, 20'h12345, 0);
    runOp(6'b110000, 32'h0000_2002, 16'h0000, 0, 1, 1, 1, 20'h12345, 0);
    curTag = "priv";
    runOp(6'b110000, 32'h8000_0000, 16'h0000, 1, 1, 1, 1, 20'h1, 0);
    runOp(6'b110000, 32'h8000_0000, 16'h0000, 0, 1, 1, 1, 20'h1, 0);
    curTag = "R6 load ignores write bit";
    runOp(6'b110100, 32'h0000_4000, 16'h0005, 0, 1, 1, 0, 20'h2, 0);
    curTag = "R6 store";
    runOp(6'b110110, 32'h0000_4000, 16'h0006, 0, 1, 1, 0, 20'h2, 0);
    curTag = "R7 priority";
    runOp(6'b110101, 32'h8000_0002, 16'h0000, 1, 0, 0, 0, 20'h3, 0);
    runOp(6'b110101, 32'h8000_0000, 16'h0000, 1, 0, 0, 0, 20'h3, 0);
    runOp(6'b110101, 32'h0000_0000, 16'h0000, 1, 0, 0, 0, 20'h3, 0);
    runOp(6'b110101, 32'h0000_0000, 16'h0000, 1, 1, 0, 0, 20'h3, 0);
    curTag = "R2 illegal opcode";
    runOp(6'b100000, 32'h0000_0001, 16'h0000, 1, 0, 0, 0, 20'h3, 0);
    runOp(6'b111000, 32'h8000_0003, 16'h0000, 1, 0, 0, 0, 20'h3, 0);
    curTag = "R10 window";
    runOp(6'b110000, 32'h0000_5000, 16'h0000, 0, 1, 1, 1, 20'h4, TMO - 1);
    runOp(6'b110000, 32'h0000_5004, 16'h0000, 0, 1, 1, 1, 20'h4, TMO + 5);
    curTag = "R12 inject";
    injectAt = 2;
    runOp(6'b110011, 32'h0000_6001, 16'h0000, 0, 1, 1, 1, 20'h5, 5);
    injectAt = -1;

    curTag = "random";
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  op;
      logic [31:0] b;
      logic [15:0] im;
      int          dly;
      op = {3'b110, 3'($urandom)};
      if ($urandom % 16 == 0) op = 6'($urandom);
      b  = $urandom;
      im = 16'($urandom);
      if ($urandom % 2 == 0) begin
        b[1:0] = 2'b00; im[1:0] = 2'b00;
      end
      dly = ($urandom % 4 == 0) ? int'($urandom % (TMO + 4)) : int'($urandom % 4);
      runOp(op, b, im, ($urandom % 10) < 3, ($urandom % 100) < 85,
            ($urandom % 100) < 85, ($urandom % 100) < 70, 20'($urandom), dly);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule